// File: doc/BRIEF.md
# Adaptive Polynomial Order Selector

This block chooses how many polynomial terms a converter's linearity correction needs. A measured integral non-linearity error curve is held elsewhere. Three candidate coefficient sets, for fits of order one, two and three, are presented on a static input bus. The block tries the fits from the lowest order upward. For each order it raises a one-cycle request and waits for the caller to replay the error samples over a valid/ready stream. Each sample is tagged with its converter code. The block evaluates the candidate polynomial at each code and accumulates the squared difference.

Once a pass is fully drained through the pipeline, the new residual energy is compared with the best one so far. The climb stops at the first order whose energy is strictly larger. It also stops after order three. The block then holds `done` together with the winning order, its mean-square residual and its coefficient set. These stay until the next start. The squares are compared as sums over the same sample count, so no square root is needed.

The stream sink deasserts `s_ready` outside a pass, and also once the pass has taken its full sample count. The source may insert gaps by holding `s_valid` low. A sample moves only on a cycle where both `s_valid` and `s_ready` are high. The source must hold `s_idx` and `s_err` steady while `s_valid` is high and `s_ready` is low. The coefficient bus must stay steady from start to `done`.

Top module: `poly_order_picker`

## Requirements
- R1: After reset, `done`, `pass_req` and `s_ready` are low.
- R2: `start` is acted on only while the block is idle or holding `done`. A `start` pulse during a search changes neither the number of passes nor the result.
- R3: Each pass begins with `pass_req` high for exactly one cycle. During that pass `s_ready` is high until 2^LOG2_NS samples have been accepted. `s_ready` is low at all other times, including while `done` is held.
- R4: A sample is consumed only on a cycle with `s_valid` and `s_ready` both high. Gaps in `s_valid` and the order in which codes are replayed do not change the result.
- R5: The candidate value at code u is computed in signed arithmetic.
  - The normalized index is x = u - 2^(IW-1).
  - The accumulator starts at c3 and takes three steps a = floor(a*x / 2^(IW-1)) + c_k, for k = 2, 1, 0.
  - Coefficients of degree above the candidate's order are taken as zero, whatever the bus holds.
  - On `coefs`, the set for order o (1..3) occupies bits [(o-1)*4*CW +: 4*CW]. Its coefficient c_k occupies CW bits at offset k*CW within that slice.
- R6: A pass's residual energy is the sum over samples of (s_err - value)^2. It saturates at 2^AW-1 instead of wrapping, and the saturated state is sticky for the pass.
- R7: Orders are tried 1, then 2, then 3. The search stops after the first order whose energy is strictly larger than the best so far, or after order 3. An order with equal energy does not replace the lower one.
- R8: A saturated candidate never displaces a non-saturated best. A non-saturated candidate always displaces a saturated best.
- R9: With `done` high:
  - `sel_order` holds the chosen order encoded 2'd1..2'd3.
  - `sel_mse` holds its energy shifted right by LOG2_NS.
  - `sel_coefs` holds its coefficient set as read from the bus.
  - All of these, with `done` itself, stay steady until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search |
| coefs | input | 12*CW | Three candidate coefficient sets, order 1 lowest |
| pass_req | output | 1 | One-cycle request to replay the error samples |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_idx | input | IW | Converter code of the sample |
| s_err | input | EW | Signed error sample |
| done | output | 1 | Search finished, results held |
| sel_order | output | 2 | Chosen order, 1 to 3 |
| sel_mse | output | AW | Mean-square residual of the chosen order |
| sel_coefs | output | 4*CW | Coefficient set of the chosen order |

## Verification
Several coefficient patterns are tried, each aimed at a different branch of the search:
- a curve whose cubic fit is exact, so the search climbs to order 3;
- a deliberately poor second-order set, so the search stops early at order 1;
- a poor third-order set, so the search settles on order 2;
- identical sets, where ties must keep order 1;
- large errors that saturate order 1, or every order, to exercise the saturation preference.

Junk in the unused high-degree slots tests the coefficient masking. Random curves with random coefficient perturbations then cover ordinary mixed outcomes. They are replayed with and without valid gaps and in forward and reversed code order, which tells a stream or indexing fault apart from an arithmetic one. One search gets a stray `start` in mid-pass.

// File: rtl/popt_pkg.sv
package popt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_EVAL,
    ST_CMP,
    ST_DONE
  } popt_state_e;

  localparam int unsigned NUM_ORD  = 3;
  localparam int unsigned NUM_TERM = 4;
endpackage

// File: rtl/popt_horner_stage.sv
module popt_horner_stage #(
  parameter int IW = 6,
  parameter int HW = 15,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [HW-1:0] in_acc,
  input  logic signed [IW-1:0] in_x,
  input  logic signed [CW-1:0] in_coef,
  output logic                 out_vld,
  output logic signed [HW-1:0] out_acc
);
  localparam int PW = HW + IW;

  logic signed [PW-1:0] prod;

  always_comb prod = PW'(in_acc) * PW'(in_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) out_acc <= HW'((prod >>> (IW - 1)) + PW'(in_coef));
  end
endmodule

// File: rtl/popt_sq_accum.sv
module popt_sq_accum #(
  parameter int EW = 12,
  parameter int HW = 15,
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [EW-1:0] in_err,
  input  logic signed [HW-1:0] in_y,
  output logic [AW-1:0]        energy,
  output logic                 sat
);
  localparam int RW = ((HW > EW) ? HW : EW) + 1;
  localparam int QW = 2 * RW;
  localparam int SW = ((AW > QW) ? AW : QW) + 1;
  localparam logic [AW-1:0] MAXV = '1;

  logic signed [RW-1:0] resid;
  logic signed [QW-1:0] rx;
  logic signed [QW-1:0] sq;
  logic [SW-1:0]        sum;

  always_comb begin
    resid = RW'(in_err) - RW'(in_y);
    rx    = QW'(resid);
    sq    = rx * rx;
    sum   = SW'(energy) + SW'($unsigned(sq));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      energy <= '0;
      sat    <= 1'b0;
    end else if (clr) begin
      energy <= '0;
      sat    <= 1'b0;
    end else if (in_vld) begin
      if (sat || (sum > SW'(MAXV))) begin
        energy <= MAXV;
        sat    <= 1'b1;
      end else begin
        energy <= AW'(sum);
      end
    end
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (energy >= $past(energy)));

  // R6
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !clr) |=> (sat && energy == MAXV));
endmodule

// File: rtl/poly_order_picker.sv
module poly_order_picker
  import popt_pkg::*;
#(
  parameter int IW      = 6,
  parameter int LOG2_NS = 6,
  parameter int EW      = 12,
  parameter int CW      = 12,
  parameter int AW      = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [12*CW-1:0]        coefs,
  output logic                    pass_req,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [IW-1:0]           s_idx,
  input  logic signed [EW-1:0]    s_err,
  output logic                    done,
  output logic [1:0]              sel_order,
  output logic [AW-1:0]           sel_mse,
  output logic [4*CW-1:0]         sel_coefs
);
  localparam int HW    = CW + 3;
  localparam int NS    = 2 ** LOG2_NS;
  localparam int CNTW  = LOG2_NS + 1;
  localparam int SETW  = NUM_TERM * CW;
  localparam int NSTG  = NUM_TERM - 1;

  popt_state_e          state;
  logic [1:0]           cur_ord;
  logic [CNTW-1:0]      in_cnt;
  logic [CNTW-1:0]      out_cnt;
  logic [SETW-1:0]      cur_set;
  logic signed [CW-1:0] cur_c [NUM_TERM];
  logic                 accept;

  logic                 vld_p [NSTG+1];
  logic signed [HW-1:0] acc_p [NSTG+1];
  logic signed [IW-1:0] x_p   [NSTG];
  logic signed [EW-1:0] err_p [NSTG+1];

  logic [AW-1:0]        cur_e;
  logic                 cur_sat;
  logic [AW-1:0]        best_e;
  logic                 best_sat;
  logic [1:0]           best_ord;
  logic [SETW-1:0]      best_set;
  logic                 worse;
  logic                 better;
  logic                 pass_end;

  // candidate coefficient set for the order under test
  always_comb begin
    case (cur_ord)
      2'd2:    cur_set = coefs[SETW +: SETW];
      2'd3:    cur_set = coefs[2*SETW +: SETW];
      default: cur_set = coefs[0 +: SETW];
    endcase
  end

  for (genvar k = 0; k < NUM_TERM; k++) begin : g_mask
    assign cur_c[k] = (k <= int'(cur_ord)) ? cur_set[k*CW +: CW] : '0;
  end

  assign s_ready  = (state == ST_EVAL) && (in_cnt < CNTW'(NS));
  assign accept   = s_valid && s_ready;
  assign pass_req = (state == ST_REQ);
  assign done     = (state == ST_DONE);

  // pipeline head: normalized index is the code with its top bit flipped
  assign vld_p[0] = accept;
  assign acc_p[0] = HW'(cur_c[NUM_TERM-1]);
  assign x_p[0]   = {~s_idx[IW-1], s_idx[IW-2:0]};
  assign err_p[0] = s_err;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    popt_horner_stage #(.IW(IW), .HW(HW), .CW(CW)) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (vld_p[s]),
      .in_acc  (acc_p[s]),
      .in_x    (x_p[s]),
      .in_coef (cur_c[NUM_TERM-2-s]),
      .out_vld (vld_p[s+1]),
      .out_acc (acc_p[s+1])
    );

    always_ff @(posedge clk) begin
      if (vld_p[s]) err_p[s+1] <= err_p[s];
    end

    if (s < NSTG - 1) begin : g_xdly
      always_ff @(posedge clk) begin
        if (vld_p[s]) x_p[s+1] <= x_p[s];
      end
    end
  end

  popt_sq_accum #(.EW(EW), .HW(HW), .AW(AW)) accum_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state == ST_REQ),
    .in_vld (vld_p[NSTG]),
    .in_err (err_p[NSTG]),
    .in_y   (acc_p[NSTG]),
    .energy (cur_e),
    .sat    (cur_sat)
  );

  assign pass_end = vld_p[NSTG] && (out_cnt == CNTW'(NS - 1));

  always_comb begin
    worse  = (cur_sat && !best_sat) || ((cur_sat == best_sat) && (cur_e > best_e));
    better = (!cur_sat && best_sat) || ((cur_sat == best_sat) && (cur_e < best_e));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_ord  <= 2'd1;
      in_cnt   <= '0;
      out_cnt  <= '0;
      best_e   <= '0;
      best_sat <= 1'b0;
      best_ord <= 2'd1;
      best_set <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state   <= ST_REQ;
            cur_ord <= 2'd1;
          end
        end
        ST_REQ: begin
          in_cnt  <= '0;
          out_cnt <= '0;
          state   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (accept)       in_cnt  <= in_cnt + 1'b1;
          if (vld_p[NSTG])  out_cnt <= out_cnt + 1'b1;
          if (pass_end)     state   <= ST_CMP;
        end
        ST_CMP: begin
          if ((cur_ord == 2'd1) || better) begin
            best_e   <= cur_e;
            best_sat <= cur_sat;
            best_ord <= cur_ord;
            best_set <= cur_set;
          end
          if (((cur_ord != 2'd1) && worse) || (cur_ord == 2'd3)) begin
            state <= ST_DONE;
          end else begin
            cur_ord <= cur_ord + 2'd1;
            state   <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_order = best_ord;
  assign sel_mse   = best_e >> LOG2_NS;
  assign sel_coefs = best_set;

  // R3
  pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_req |=> !pass_req);

  // R3
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMP) |-> ((in_cnt == CNTW'(NS)) && (out_cnt == CNTW'(NS))));

  // R4
  order_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVAL) |-> (out_cnt <= in_cnt));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state == ST_EVAL)) |=> (cur_ord == $past(cur_ord)));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sel_order) && $stable(sel_mse)
                          && $stable(sel_coefs)));

  // R9
  order_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sel_order != 2'd0));

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || pass_req) |-> !s_ready);
endmodule

// File: tb/poly_order_picker_tb_top.sv
module poly_order_picker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 6;
  localparam int LOG2_NS = 6;
  localparam int NS = 64;
  localparam int EW = 12;
  localparam int CW = 12;
  localparam int AW = 28;
  localparam longint MAXE = (64'd1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [12*CW-1:0] coefs;
  logic pass_req;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [IW-1:0] s_idx = '0;
  logic signed [EW-1:0] s_err = '0;
  logic done;
  logic [1:0] sel_order;
  logic [AW-1:0] sel_mse;
  logic [4*CW-1:0] sel_coefs;

  logic signed [CW-1:0] cf [1:3][0:3];
  logic signed [EW-1:0] err [0:NS-1];

  int nchecks = 0;
  int nfails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int o = 1; o <= 3; o++)
      for (int k = 0; k < 4; k++)
        coefs[((o-1)*4+k)*CW +: CW] = cf[o][k];
  end

  poly_order_picker #(.IW(IW), .LOG2_NS(LOG2_NS), .EW(EW), .CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .coefs(coefs), .pass_req(pass_req),
    .s_valid(s_valid), .s_ready(s_ready), .s_idx(s_idx), .s_err(s_err),
    .done(done), .sel_order(sel_order), .sel_mse(sel_mse), .sel_coefs(sel_coefs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
    end
  end

  // R5 model: x = u - 32, three floor steps starting from c3, masked terms
  function automatic longint eval_c(input longint a0, input longint a1,
                                    input longint a2, input longint a3, input int u);
    longint x = longint'(u) - 32;
    longint a = a3;
    a = ((a * x) >>> 5) + a2;
    a = ((a * x) >>> 5) + a1;
    a = ((a * x) >>> 5) + a0;
    return a;
  endfunction

  function automatic longint eval_ord(input int o, input int u);
    longint c [4];
    for (int k = 0; k < 4; k++) c[k] = (k <= o) ? longint'(cf[o][k]) : 0;
    return eval_c(c[0], c[1], c[2], c[3], u);
  endfunction

  // R6/R7/R8 model
  task automatic model(output int ord, output longint e_best, output int passes);
    longint e [1:3];
    bit s [1:3];
    bit w, b, bs;
    for (int o = 1; o <= 3; o++) begin
      e[o] = 0; s[o] = 0;
      for (int u = 0; u < NS; u++) begin
        longint r = longint'(err[u]) - eval_ord(o, u);
        e[o] = e[o] + r * r;
        if (s[o] || e[o] > MAXE) begin s[o] = 1; e[o] = MAXE; end
      end
    end
    ord = 1; e_best = e[1]; bs = s[1]; passes = 1;
    for (int o = 2; o <= 3; o++) begin
      passes++;
      w = (s[o] && !bs) || (s[o] == bs && e[o] > e_best);
      b = (!s[o] && bs) || (s[o] == bs && e[o] < e_best);
      if (b) begin ord = o; e_best = e[o]; bs = s[o]; end
      if (w) break;
    end
  endtask

  task automatic replay(input bit gaps, input bit rev, input bit poke);
    bit ok;
    for (int n = 0; n < NS; n++) begin
      int u = rev ? (NS - 1 - n) : n;
      s_valid = 1'b0;
      if (gaps) while ($urandom_range(3) == 0) @(negedge clk);
      s_idx = IW'(u);
      s_err = err[u];
      s_valid = 1'b1;
      if (poke && n == 10) start = 1'b1;
      do begin
        ok = s_ready;
        @(negedge clk);
        start = 1'b0;
      end while (!ok);
    end
    s_valid = 1'b0;
  endtask

  task automatic run_trial(input string tag, input bit gaps, input bit rev, input bit poke);
    int exp_ord, exp_passes, passes, guard;
    longint exp_e;
    logic [1:0] ord0;
    model(exp_ord, exp_e, exp_passes);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    passes = 0;
    guard = 0;
    while (!done && guard < 20000) begin
      if (pass_req) begin
        passes++;
        replay(gaps, rev, poke && passes == 2);
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(done === 1'b1, "R7", {tag, " done reached"}, done, 1);
    chk(sel_order == 2'(exp_ord), "R7", {tag, " order"}, sel_order, exp_ord);
    chk(passes == exp_passes, "R7", {tag, " pass count"}, passes, exp_passes);
    chk(sel_mse == AW'(exp_e >> LOG2_NS), "R9", {tag, " mse"}, sel_mse, exp_e >> LOG2_NS);
    for (int k = 0; k < 4; k++)
      chk(sel_coefs[k*CW +: CW] == cf[exp_ord][k], "R9", {tag, " coef"},
          sel_coefs[k*CW +: CW], cf[exp_ord][k]);
    chk(s_ready == 1'b0, "R3", {tag, " ready low at done"}, s_ready, 0);
    ord0 = sel_order;
    repeat (5) @(negedge clk);
    chk(done && sel_order == ord0, "R9", {tag, " done held"}, sel_order, ord0);
  endtask

  task automatic set_all(input int o, input int a0, input int a1, input int a2, input int a3);
    cf[o][0] = CW'(a0); cf[o][1] = CW'(a1); cf[o][2] = CW'(a2); cf[o][3] = CW'(a3);
  endtask

  function automatic int rnd(input int m);
    return int'($urandom_range(2 * m)) - m;
  endfunction

  initial begin
    for (int o = 1; o <= 3; o++) set_all(o, 0, 0, 0, 0);
    for (int u = 0; u < NS; u++) err[u] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(pass_req == 1'b0, "R1", "pass_req after reset", pass_req, 0);
    chk(s_ready == 1'b0, "R1", "s_ready after reset", s_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // exact cubic, junk in masked slots (R5)
    for (int u = 0; u < NS; u++) err[u] = EW'(eval_c(100, -300, 200, 400, u));
    set_all(1, 100, -300, 1500, -1700);
    set_all(2, 100, -300, 200, 1999);
    set_all(3, 100, -300, 200, 400);
    run_trial("cubic R5", 1'b0, 1'b0, 1'b0);

    set_all(2, 100, -300, -900, 700);
    run_trial("bad second", 1'b1, 1'b0, 1'b0);

    set_all(2, 100, -300, 200, 0);
    set_all(3, 100, -300, 200, -1500);
    run_trial("bad third", 1'b0, 1'b1, 1'b0);

    // ties keep lower order
    for (int u = 0; u < NS; u++) err[u] = EW'(eval_c(50, 60, 0, 0, u));
    set_all(1, 50, 60, 0, 0);
    set_all(2, 50, 60, 0, 0);
    set_all(3, 50, 60, 0, 0);
    run_trial("ties R7", 1'b1, 1'b1, 1'b0);

    // saturation preference (R8)
    for (int u = 0; u < NS; u++) err[u] = 12'sd2047;
    set_all(1, -2048, -2048, 0, 0);
    set_all(2, 2047, 0, 0, 0);
    set_all(3, 2047, 0, 0, 0);
    run_trial("sat first R8", 1'b0, 1'b0, 1'b0);
    set_all(2, -2048, -2048, -2048, 0);
    set_all(3, -2048, -2048, -2048, -2048);
    run_trial("sat all R6", 1'b1, 1'b0, 1'b0);

    // stray start mid-pass (R2)
    for (int u = 0; u < NS; u++) err[u] = EW'(eval_c(-80, 150, -120, 90, u) + rnd(10));
    set_all(1, -80, 150, 5, 5);
    set_all(2, -80, 150, -120, 5);
    set_all(3, -70, 140, -110, 95);
    run_trial("busy start R2", 1'b1, 1'b0, 1'b1);

    // random curves and perturbed fits (R4 gaps and ordering)
    for (int t = 0; t < 30; t++) begin
      int c0 = rnd(200), c1 = rnd(200), c2 = rnd(200), c3 = rnd(200);
      for (int u = 0; u < NS; u++) err[u] = EW'(eval_c(c0, c1, c2, c3, u) + rnd(15));
      set_all(1, c0 + rnd(40), c1 + rnd(40), rnd(2000), rnd(2000));
      set_all(2, c0 + rnd(40), c1 + rnd(40), c2 + rnd(60), rnd(2000));
      set_all(3, c0 + rnd(40), c1 + rnd(40), c2 + rnd(60), c3 + rnd(80));
      run_trial("random R4", t[0], t[1], 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  end
endmodule